// File: doc/BRIEF.md
# Interrupt Pin Request and Re-delivery Engine

This block holds the request state of every input pin of an I/O interrupt controller and decides when each pin must be handed to the delivery fabric. Pin level changes come in as single events, each naming a pin and a new level, and each gets a one-cycle response saying whether it was absorbed as coalesced. The routing fields of every pin stay in an external table and are read by the engine as static inputs: mask, trigger kind, vector and destination. A write strobe tells the engine when one entry has been rewritten. Destination matching and the processors are outside.

Edge pins hold a request bit that a second assertion cannot raise again, so a repeat that arrives before the pin drops is coalesced. Level pins are gated by a remote-pending bit that a successful delivery sets and that an end-of-interrupt (EOI) message with the pin's vector clears. An EOI re-fires a pin that is still requesting. A per-pin counter of back-to-back EOI re-fires detects an interrupt storm. At the limit, the immediate re-fire is replaced by a sweep after a programmable delay, and the sweep services every idle requesting level pin. All service work passes through a round-robin arbiter that issues at most one request per clock.

Top module: `irq_pin_engine`

## Requirements
- R1: A deassert event clears the pin's request bit. The response one cycle later has resp_valid=1 and resp_coalesced=0.
- R2: For an edge pin (cfg_level_trig bit = 0), an assert event while the request bit is already set returns resp_coalesced=1 and produces no request. Otherwise the event sets the request bit and, if the pin is unmasked, produces exactly one request carrying the pin index, its vector, its destination and req_level_trig=0.
- R3: For a level pin (cfg_level_trig bit = 1), an assert event while remote-pending is set returns resp_coalesced=1 and produces no request. The request bit is still set.
- R4: An edge assert event clears the pin's edge_dlvd_o bit. Servicing an unmasked edge pin sets that bit.
- R5: A pin whose cfg_mask bit is 1 at service time produces no request.
- R6: A request for a level pin that is answered with dlv_ok=1 sets the pin's remote-pending bit. A request answered with dlv_ok=0 leaves the bit clear.
- R7: A level EOI (eoi_level_trig=1, eoi_directed=0) whose vector matches a level pin clears that pin's remote-pending bit. If the pin is unmasked and its request bit is set, the pin is serviced again. With eoi_directed=1 the EOI changes nothing.
- R8: The storm counter of a pin returns to zero on any acting EOI that finds the pin masked or its request bit clear.
- R9: The STORM_LIMIT-th back-to-back EOI re-fire of a pin produces no immediate request. It starts a delay of about DEFER_CYCLES clocks and resets the counter.
- R10: When the delay ends, every level pin with its request bit set and remote-pending clear is serviced.
- R11: An entry write strobe clears the pin's remote-pending bit. If the pin is level and its request bit is set, the strobe triggers a service.
- R12: At most one request is issued per clock. Pending pins are granted in round-robin order, starting from the index after the last granted pin (index 0 after reset). After reset no request bit, remote-pending bit or delivered bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | A pin level event is present |
| evt_pin | input | IDX_W | Pin index of the event |
| evt_level | input | 1 | New level: 1 assert, 0 deassert |
| cfg_mask | input | NPINS | Per-pin mask from the entry table |
| cfg_level_trig | input | NPINS | Per-pin trigger kind, 1 level, 0 edge |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination, pin i at bits [i*DEST_W +: DEST_W] |
| cfg_wr_valid | input | 1 | An entry of the table was rewritten |
| cfg_wr_pin | input | IDX_W | Index of the rewritten entry |
| eoi_valid | input | 1 | An EOI broadcast is present |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_level_trig | input | 1 | The EOI is for a level interrupt |
| eoi_directed | input | 1 | Directed-EOI mode: the broadcast is not acted on |
| dlv_ok | input | 1 | Same-cycle success of the current request |
| req_valid | output | 1 | Delivery request present |
| req_pin | output | IDX_W | Pin being delivered |
| req_vector | output | VEC_W | Vector of the request |
| req_dest | output | DEST_W | Destination of the request |
| req_level_trig | output | 1 | Trigger kind of the request |
| resp_valid | output | 1 | Response to the previous cycle's event |
| resp_coalesced | output | 1 | That event was coalesced |
| irr_o | output | NPINS | Request bits |
| remote_irr_o | output | NPINS | Remote-pending bits |
| edge_dlvd_o | output | NPINS | Edge-delivered bits |

## Verification
The embedded properties check, on every clock, that the arbiter never grants two pins at once and that remote-pending rises only after a successful level delivery. They also check that the delivered bit rises only after an unmasked grant, that a deassert always leaves the request bit clear, that the storm counter stays below its limit, and that the sweep fires only out of a running delay. Whole sequences only show up in the bench scenarios: coalescing against earlier events, re-fire after EOI, the counter reset by a masked EOI, the deferred sweep reaching several pins, and the grant order after a multi-pin EOI.

// File: rtl/irq_eng_pkg.sv
// Shared definitions of the pin request engine.
// Assumes: pin counts of at least two.
package irq_eng_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Next round-robin start index after a grant at idx.
    function automatic int rr_after(input int idx, input int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/irq_rr_arb.sv
// Round-robin grant of one pending pin per clock.
// Assumes: the requester drops a granted bit on the following edge.
module irq_rr_arb #(
    parameter int NPINS = 24,
    localparam int IW   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] req,
    output logic [NPINS-1:0] gnt,
    output logic             gnt_valid,
    output logic [IW-1:0]    gnt_idx
);
    import irq_eng_pkg::*;

    logic [IW-1:0] ptr;

    // Search from ptr upward with wrap and pick the first pending pin.
    always_comb begin
        gnt       = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < NPINS; k++) begin
            int p;
            p = (int'(ptr) + k) % NPINS;
            if (!gnt_valid && req[p]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(p);
                gnt[p]    = 1'b1;
            end
        end
    end

    // Move the start point past the pin just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (gnt_valid)
            ptr <= IW'(rr_after(int'(gnt_idx), NPINS));
    end

    a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r12_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/irq_defer_timer.sv
// One-shot delay for storm-deferred re-injection: an arm pulse while idle
// starts a countdown, and its end yields a one-cycle fire pulse.
// Assumes: arms that arrive while counting fold into the running delay.
module irq_defer_timer #(
    parameter int DEFER_CYCLES = 1000000,
    localparam int TW          = $clog2(DEFER_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    logic          busy;
    logic [TW-1:0] left;

    // Count the delay down and emit fire when it is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!busy) begin
                if (arm) begin
                    busy <= 1'b1;
                    left <= TW'(DEFER_CYCLES - 1);
                end
            end else if (left == '0) begin
                busy <= 1'b0;
                fire <= 1'b1;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    a_r9_fire_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(busy));
endmodule

// File: rtl/irq_pin_slice.sv
// State of one pin: request bit, edge-delivered bit, remote-pending bit,
// service-pending flag and EOI storm counter.
// Assumes: at most one event, one EOI and one entry write per clock.
module irq_pin_slice #(
    parameter int STORM_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_hit,
    input  logic evt_level,
    input  logic mask,
    input  logic level_trig,
    input  logic eoi_hit,
    input  logic eoi_level_trig,
    input  logic eoi_directed,
    input  logic cfg_hit,
    input  logic grant_hit,
    input  logic dlv_hit,
    input  logic defer_fire,
    output logic irr,
    output logic edge_dlvd,
    output logic rirr,
    output logic pend,
    output logic coalesced,
    output logic storm
);
    localparam int CW = $clog2(STORM_LIMIT + 1);

    logic          assert_evt, drop_evt, eoi_act, eoi_redo, pend_set;
    logic [CW-1:0] cnt, cnt_next;

    // Classify this cycle's stimulus and decide whether service is needed.
    always_comb begin
        assert_evt = evt_hit & evt_level;
        drop_evt   = evt_hit & ~evt_level;
        coalesced  = assert_evt & (level_trig ? rirr : irr);
        eoi_act    = eoi_hit & eoi_level_trig & ~eoi_directed & level_trig;
        eoi_redo   = eoi_act & ~mask & irr;
        cnt_next   = cnt + 1'b1;
        storm      = eoi_redo & (cnt_next == CW'(STORM_LIMIT));
        pend_set   = (assert_evt & ~coalesced)
                   | (eoi_redo & ~storm)
                   | (cfg_hit & level_trig & irr)
                   | (defer_fire & level_trig & irr & ~rirr);
    end

    // Update the per-pin state bits and the storm counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr       <= 1'b0;
            edge_dlvd <= 1'b0;
            rirr      <= 1'b0;
            pend      <= 1'b0;
            cnt       <= '0;
        end else begin
            if (drop_evt)
                irr <= 1'b0;
            else if (assert_evt)
                irr <= 1'b1;

            if (grant_hit && !level_trig && !mask)
                edge_dlvd <= 1'b1;
            else if (assert_evt && !level_trig)
                edge_dlvd <= 1'b0;

            if (dlv_hit && level_trig)
                rirr <= 1'b1;
            else if (eoi_act || cfg_hit)
                rirr <= 1'b0;

            if (pend_set)
                pend <= 1'b1;
            else if (grant_hit)
                pend <= 1'b0;

            if (eoi_act)
                cnt <= (eoi_redo && !storm) ? cnt_next : '0;
        end
    end

    a_r1_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> !irr);
    a_r6_rirr_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rirr) |-> $past(dlv_hit && level_trig));
    a_r4_dlvd_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_dlvd) |-> $past(grant_hit && !mask));
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(STORM_LIMIT));
endmodule

// File: rtl/irq_pin_engine.sv
// Top of the pin request engine: one slice per pin, a round-robin arbiter
// that issues one registered request per clock, and the storm delay timer.
// Assumes: dlv_ok answers the request visible in the same cycle.
module irq_pin_engine #(
    parameter int NPINS        = 24,
    parameter int VEC_W        = 8,
    parameter int DEST_W       = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 1000000,
    localparam int IDX_W       = $clog2(NPINS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_valid,
    input  logic [IDX_W-1:0]        evt_pin,
    input  logic                    evt_level,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic [NPINS-1:0]        cfg_level_trig,
    input  logic [NPINS*VEC_W-1:0]  cfg_vector,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic                    cfg_wr_valid,
    input  logic [IDX_W-1:0]        cfg_wr_pin,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    input  logic                    eoi_level_trig,
    input  logic                    eoi_directed,
    input  logic                    dlv_ok,
    output logic                    req_valid,
    output logic [IDX_W-1:0]        req_pin,
    output logic [VEC_W-1:0]        req_vector,
    output logic [DEST_W-1:0]       req_dest,
    output logic                    req_level_trig,
    output logic                    resp_valid,
    output logic                    resp_coalesced,
    output logic [NPINS-1:0]        irr_o,
    output logic [NPINS-1:0]        remote_irr_o,
    output logic [NPINS-1:0]        edge_dlvd_o
);
    import irq_eng_pkg::*;

    logic [NPINS-1:0] pend, gnt, coal, storm, lvl;
    logic             gnt_valid, defer_fire;
    logic [IDX_W-1:0] gnt_idx;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            assign lvl[i] = (cfg_level_trig[i] == TRIG_LEVEL);
            irq_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) i_slice (
                .clk            (clk),
                .rst_n          (rst_n),
                .evt_hit        (evt_valid && evt_pin == IDX_W'(i)),
                .evt_level      (evt_level),
                .mask           (cfg_mask[i]),
                .level_trig     (lvl[i]),
                .eoi_hit        (eoi_valid &&
                                 cfg_vector[i*VEC_W +: VEC_W] == eoi_vector),
                .eoi_level_trig (eoi_level_trig),
                .eoi_directed   (eoi_directed),
                .cfg_hit        (cfg_wr_valid && cfg_wr_pin == IDX_W'(i)),
                .grant_hit      (gnt[i]),
                .dlv_hit        (req_valid && req_pin == IDX_W'(i) && dlv_ok),
                .defer_fire     (defer_fire),
                .irr            (irr_o[i]),
                .edge_dlvd      (edge_dlvd_o[i]),
                .rirr           (remote_irr_o[i]),
                .pend           (pend[i]),
                .coalesced      (coal[i]),
                .storm          (storm[i])
            );
        end
    endgenerate

    irq_rr_arb #(.NPINS(NPINS)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pend),
        .gnt       (gnt),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    irq_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) i_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (|storm),
        .fire  (defer_fire)
    );

    // Register the granted pin as a request unless its entry is masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid      <= 1'b0;
            req_pin        <= '0;
            req_vector     <= '0;
            req_dest       <= '0;
            req_level_trig <= 1'b0;
        end else begin
            req_valid      <= gnt_valid && !cfg_mask[gnt_idx];
            req_pin        <= gnt_idx;
            req_vector     <= cfg_vector[gnt_idx*VEC_W +: VEC_W];
            req_dest       <= cfg_dest[gnt_idx*DEST_W +: DEST_W];
            req_level_trig <= lvl[gnt_idx];
        end
    end

    // Report the outcome of each pin event one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_coalesced <= 1'b0;
        end else begin
            resp_valid     <= evt_valid;
            resp_coalesced <= |coal;
        end
    end

    a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && cfg_mask[gnt_idx]) |=> !req_valid);
    a_r1_resp_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(evt_valid));
endmodule

// File: tb/test_irq_pin_engine.sv
module test_irq_pin_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int VW  = 8;
    localparam int DW  = 8;
    localparam int LIM = 4;
    localparam int DEF = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           evt_valid = 1'b0;
    logic [2:0]     evt_pin = '0;
    logic           evt_level = 1'b0;
    logic [NP-1:0]  cfg_mask = '0;
    logic [NP-1:0]  cfg_level_trig = '0;
    logic [NP*VW-1:0] cfg_vector;
    logic [NP*DW-1:0] cfg_dest;
    logic           cfg_wr_valid = 1'b0;
    logic [2:0]     cfg_wr_pin = '0;
    logic           eoi_valid = 1'b0;
    logic [VW-1:0]  eoi_vector = '0;
    logic           eoi_level_trig = 1'b0;
    logic           eoi_directed = 1'b0;
    logic           dlv_ok = 1'b1;
    logic           req_valid;
    logic [2:0]     req_pin;
    logic [VW-1:0]  req_vector;
    logic [DW-1:0]  req_dest;
    logic           req_level_trig;
    logic           resp_valid, resp_coalesced;
    logic [NP-1:0]  irr_o, remote_irr_o, edge_dlvd_o;

    irq_pin_engine #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW),
                     .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) i_irq_pin_engine (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_pin(evt_pin),
        .evt_level(evt_level), .cfg_mask(cfg_mask),
        .cfg_level_trig(cfg_level_trig), .cfg_vector(cfg_vector),
        .cfg_dest(cfg_dest), .cfg_wr_valid(cfg_wr_valid),
        .cfg_wr_pin(cfg_wr_pin), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .eoi_level_trig(eoi_level_trig),
        .eoi_directed(eoi_directed), .dlv_ok(dlv_ok),
        .req_valid(req_valid), .req_pin(req_pin), .req_vector(req_vector),
        .req_dest(req_dest), .req_level_trig(req_level_trig),
        .resp_valid(resp_valid), .resp_coalesced(resp_coalesced),
        .irr_o(irr_o), .remote_irr_o(remote_irr_o), .edge_dlvd_o(edge_dlvd_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, n_req = 0;
    bit done = 1'b0;
    int rec_pin [0:15];
    int last_vec, last_dest, last_lvl;
    bit m_irr [NP], m_rirr [NP], m_dlvd [NP];

    // Record every request seen on the output.
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (n_req < 16) rec_pin[n_req] = int'(req_pin);
            last_vec  = int'(req_vector);
            last_dest = int'(req_dest);
            last_lvl  = int'(req_level_trig);
            n_req++;
        end
    end

    function automatic int vec_of(int p);
        return int'(cfg_vector[p*VW +: VW]);
    endfunction
    function automatic int dest_of(int p);
        return (p * 3 + 1) & 8'hff;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        for (int i = 0; i < NP; i++) begin
            m_irr[i] = 0; m_rirr[i] = 0; m_dlvd[i] = 0;
        end
        wait_n(1);
    endtask

    task automatic send_evt(int p, bit lvl, output bit coal);
        @(negedge clk);
        n_req = 0;
        evt_valid = 1'b1; evt_pin = 3'(p); evt_level = lvl;
        @(negedge clk);
        evt_valid = 1'b0;
        coal = resp_coalesced;
        chk(resp_valid == 1'b1, "R1 resp_valid", int'(resp_valid), 1);
        wait_n(5);
    endtask

    task automatic send_eoi(int v, bit directed, int settle);
        @(negedge clk);
        n_req = 0;
        eoi_valid = 1'b1; eoi_vector = 8'(v);
        eoi_level_trig = 1'b1; eoi_directed = directed;
        @(negedge clk);
        eoi_valid = 1'b0; eoi_directed = 1'b0;
        wait_n(settle);
    endtask

    task automatic send_cfg(int p);
        @(negedge clk);
        n_req = 0;
        cfg_wr_valid = 1'b1; cfg_wr_pin = 3'(p);
        @(negedge clk);
        cfg_wr_valid = 1'b0;
        wait_n(5);
    endtask

    // Compare one pin's state bits against the model.
    task automatic chk_pin(int p, string tag);
        chk(irr_o[p] == m_irr[p], {tag, " irr"}, int'(irr_o[p]), int'(m_irr[p]));
        chk(remote_irr_o[p] == m_rirr[p], {tag, " rirr"},
            int'(remote_irr_o[p]), int'(m_rirr[p]));
        chk(edge_dlvd_o[p] == m_dlvd[p], {tag, " dlvd"},
            int'(edge_dlvd_o[p]), int'(m_dlvd[p]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end

    initial begin
        bit coal;
        bit exp_coal;
        int exp_req;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) begin
            cfg_vector[i*VW +: VW] = 8'(8'h40 + i);
            cfg_dest[i*DW +: DW]   = 8'(dest_of(i));
        end
        do_reset();
        chk(irr_o == '0 && remote_irr_o == '0 && edge_dlvd_o == '0,
            "R12 reset state", int'(irr_o | remote_irr_o | edge_dlvd_o), 0);
        chk(req_valid == 1'b0, "R12 reset idle", int'(req_valid), 0);

        // Random phase: events and entry writes against a bench model.
        for (int i = 0; i < NP; i++) begin
            cfg_mask[i]       = (($urandom % 4) == 0);
            cfg_level_trig[i] = 1'($urandom % 2);
        end
        for (int n = 0; n < 160; n++) begin
            int p, act;
            p = int'($urandom % NP);
            act = int'($urandom % 5);
            dlv_ok = 1'($urandom % 2);
            exp_req = 0;
            if (act == 4) begin
                m_rirr[p] = 0;
                if (cfg_level_trig[p] && m_irr[p] && !cfg_mask[p]) begin
                    exp_req = 1;
                    if (dlv_ok) m_rirr[p] = 1;
                end
                send_cfg(p);
                chk(n_req == exp_req, "R11 entry write service", n_req, exp_req);
            end else if (act == 0) begin
                m_irr[p] = 0;
                send_evt(p, 1'b0, coal);
                chk(coal == 1'b0, "R1 deassert not coalesced", int'(coal), 0);
                chk(n_req == 0, "R1 deassert no request", n_req, 0);
            end else begin
                if (!cfg_level_trig[p]) begin
                    exp_coal = m_irr[p];
                    m_dlvd[p] = 0;
                    if (!exp_coal) begin
                        m_irr[p] = 1;
                        if (!cfg_mask[p]) begin
                            exp_req = 1; m_dlvd[p] = 1;
                        end
                    end
                end else begin
                    exp_coal = m_rirr[p];
                    m_irr[p] = 1;
                    if (!exp_coal && !cfg_mask[p]) begin
                        exp_req = 1;
                        if (dlv_ok) m_rirr[p] = 1;
                    end
                end
                send_evt(p, 1'b1, coal);
                chk(coal == exp_coal, cfg_level_trig[p] ? "R3 coalesced" : "R2 coalesced",
                    int'(coal), int'(exp_coal));
                chk(n_req == exp_req, cfg_mask[p] ? "R5 masked request count" :
                    "R2 request count", n_req, exp_req);
                if (exp_req == 1 && n_req == 1) begin
                    chk(rec_pin[0] == p, "R2 request pin", rec_pin[0], p);
                    chk(last_vec == vec_of(p), "R2 request vector", last_vec, vec_of(p));
                    chk(last_dest == dest_of(p), "R2 request dest", last_dest, dest_of(p));
                    chk(last_lvl == int'(cfg_level_trig[p]), "R2 request trigger",
                        last_lvl, int'(cfg_level_trig[p]));
                end
            end
            chk_pin(p, "R4 R6 state");
        end

        // Directed edge corners on pin 0.
        do_reset();
        dlv_ok = 1'b1;
        cfg_mask = '0; cfg_level_trig = '0;
        cfg_mask[0] = 1'b1;
        send_evt(0, 1'b1, coal);
        chk(n_req == 0, "R5 masked edge silent", n_req, 0);
        chk(edge_dlvd_o[0] == 1'b0, "R4 masked not delivered", int'(edge_dlvd_o[0]), 0);
        send_evt(0, 1'b1, coal);
        chk(coal == 1'b1, "R2 repeat edge coalesced", int'(coal), 1);
        chk(n_req == 0, "R2 coalesced no request", n_req, 0);
        cfg_mask[0] = 1'b0;
        send_evt(0, 1'b0, coal);
        chk(irr_o[0] == 1'b0, "R1 deassert clears", int'(irr_o[0]), 0);
        send_evt(0, 1'b1, coal);
        chk(n_req == 1, "R2 fresh edge delivered", n_req, 1);
        chk(edge_dlvd_o[0] == 1'b1, "R4 delivered bit set", int'(edge_dlvd_o[0]), 1);
        send_evt(0, 1'b1, coal);
        chk(coal == 1'b1 && edge_dlvd_o[0] == 1'b0, "R4 repeat clears delivered",
            int'(edge_dlvd_o[0]), 0);

        // Level pin 2: remote-pending, EOI, storm and deferred sweep.
        do_reset();
        cfg_level_trig = 8'b0000_1100;
        dlv_ok = 1'b1;
        send_evt(2, 1'b1, coal);
        chk(n_req == 1 && remote_irr_o[2] == 1'b1, "R6 level success sets rirr",
            int'(remote_irr_o[2]), 1);
        send_evt(2, 1'b1, coal);
        chk(coal == 1'b1 && n_req == 0, "R3 level gated by rirr", int'(coal), 1);
        send_eoi(8'h42, 1'b1, 5);
        chk(remote_irr_o[2] == 1'b1 && n_req == 0, "R7 directed EOI ignored",
            int'(remote_irr_o[2]), 1);
        for (int k = 0; k < LIM - 1; k++) begin
            send_eoi(8'h42, 1'b0, 5);
            chk(n_req == 1, "R7 EOI re-delivers", n_req, 1);
        end
        dlv_ok = 1'b0;
        send_evt(3, 1'b1, coal);
        chk(n_req == 1 && remote_irr_o[3] == 1'b0, "R6 failed delivery keeps rirr clear",
            int'(remote_irr_o[3]), 0);
        dlv_ok = 1'b1;
        send_eoi(8'h42, 1'b0, DEF - 10);
        chk(n_req == 0, "R9 storm delays re-delivery", n_req, 0);
        wait_n(30);
        chk(n_req == 2, "R10 sweep services idle level pins", n_req, 2);
        chk(remote_irr_o[3:2] == 2'b11, "R10 sweep delivered both",
            int'(remote_irr_o[3:2]), 3);

        // Counter reset by a masked EOI, then entry write re-service.
        for (int k = 0; k < LIM - 1; k++) send_eoi(8'h42, 1'b0, 5);
        cfg_mask[2] = 1'b1;
        send_eoi(8'h42, 1'b0, 5);
        chk(n_req == 0 && remote_irr_o[2] == 1'b0, "R8 masked EOI clears, no request",
            n_req, 0);
        cfg_mask[2] = 1'b0;
        send_cfg(2);
        chk(n_req == 1, "R11 entry write services level pin", n_req, 1);
        send_eoi(8'h42, 1'b0, 5);
        chk(n_req == 1, "R8 counter restarted", n_req, 1);

        // Round-robin order after a shared-vector EOI.
        do_reset();
        cfg_mask = '0;
        cfg_level_trig = 8'b0101_0010;
        cfg_vector[1*VW +: VW] = 8'h77;
        cfg_vector[4*VW +: VW] = 8'h77;
        cfg_vector[6*VW +: VW] = 8'h77;
        dlv_ok = 1'b0;
        send_evt(4, 1'b1, coal);
        send_evt(6, 1'b1, coal);
        send_evt(1, 1'b1, coal);
        send_eoi(8'h77, 1'b0, 6);
        chk(n_req == 3, "R12 three grants", n_req, 3);
        chk(rec_pin[0] == 4 && rec_pin[1] == 6 && rec_pin[2] == 1,
            "R12 round-robin order", rec_pin[0] * 100 + rec_pin[1] * 10 + rec_pin[2], 461);

        finish_run();
    end
endmodule